// File: doc/BRIEF.md
# Half-Precision Sign Injection Unit

This unit forms the result of the three half-precision sign-injection operations on operands held in 64-bit floating-point registers. The three operations are copy-sign, negated-sign and XOR-sign. The magnitude bits always come from the first operand. The sign bit, which is bit 15, is derived from the second operand or from both operands. The logic is combinational, and the result is captured in an output register one cycle after the request.

In boxed mode, a half value is valid only when bits 63:16 of its register are all ones. Before use, each operand is checked for this. An operand that fails the check is replaced by the boxed canonical half NaN. In integer-register mode there is no check. Both operands are used exactly as given, and the 16-bit result is sign-extended from bit 15 across the 64-bit output. When the caller signals that both operands name the same register, the operations become move, negate and absolute value. In that case only the first operand is read.

Top module: `hsgn_inject`

## Requirements
- R1: Result bits 14:0 equal bits 14:0 of the first operand after its box check. This holds for every legal operation.
- R2: Copy-sign is select 2'b00. Bit 15 comes from the checked second operand, and bits 63:16 come from the checked second operand.
- R3: Negated-sign is select 2'b01. Bit 15 is the inverse of bit 15 of the checked second operand, and bits 63:16 come from the checked first operand.
- R4: XOR-sign is select 2'b10. Bit 15 is the XOR of bit 15 of both checked operands, and bits 63:16 come from the checked first operand.
- R5: With the same-register flag set, the second operand has no effect on the result. Copy-sign returns the checked first operand, negated-sign flips its bit 15, and XOR-sign clears its bit 15.
- R6: In boxed mode (mode bit 0), an operand whose bits 63:16 are not all ones is replaced by 64'hFFFF_FFFF_FFFF_7E00 before the operation.
- R7: In integer-register mode (mode bit 1), operands are not checked. Result bits 63:16 all equal result bit 15.
- R8: Select 2'b11 is illegal. The result register loads the first operand unchanged, and output valid stays low.
- R9: Output valid is high exactly one cycle after a legal request with input valid high. Reset clears output valid and the result. The result holds while input valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 64 | First operand register value |
| op_b | input | 64 | Second operand register value |
| same_reg | input | 1 | Both operands come from one register |
| op_sel | input | 2 | 00 copy, 01 negate, 10 XOR, 11 illegal |
| int_mode | input | 1 | 1: integer-register storage, 0: boxed storage |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered result |

## Verification
Three input features interact, and random draws rarely land on the combinations that matter. The first is an operand that fails the box check in boxed mode. The second is the same-register flag with a second operand that differs from the first. The third is the illegal select.

The stimulus uses random upper halves that are all ones half of the time, so both passing and failing box checks occur often. Directed cases then pair a malformed second operand with the same-register flag, where that operand must have no effect. They also pair the illegal select with a malformed first operand, which must come out untouched.

// File: rtl/hsgn_inject.sv
module hsgn_inject #(
  parameter int FLEN = 64,
  parameter int HALF = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [FLEN-1:0] op_a,
  input  logic [FLEN-1:0] op_b,
  input  logic            same_reg,
  input  logic [1:0]      op_sel,
  input  logic            int_mode,
  output logic            out_valid,
  output logic [FLEN-1:0] result
);
  localparam int SB = HALF - 1;
  localparam int HI = FLEN - HALF;
  localparam logic [FLEN-1:0] CANON = {{HI{1'b1}}, 16'h7E00};

  logic [FLEN-1:0] ca, cb, pre, fin, nxt;
  logic [HI-1:0]   upper;
  logic            sgn;

  assign ca = (int_mode || &op_a[FLEN-1:HALF]) ? op_a : CANON;
  assign cb = (int_mode || &op_b[FLEN-1:HALF]) ? op_b : CANON;

  always_comb begin
    upper = ca[FLEN-1:HALF];
    sgn   = ca[SB];
    if (same_reg) begin
      case (op_sel)
        2'b01:   sgn = ~ca[SB];
        2'b10:   sgn = 1'b0;
        default: sgn = ca[SB];
      endcase
    end else begin
      case (op_sel)
        2'b00: begin
          upper = cb[FLEN-1:HALF];
          sgn   = cb[SB];
        end
        2'b01:   sgn = ~cb[SB];
        2'b10:   sgn = ca[SB] ^ cb[SB];
        default: sgn = ca[SB];
      endcase
    end
  end

  assign pre = {upper, sgn, ca[SB-1:0]};
  assign fin = int_mode ? {{HI{pre[SB]}}, pre[HALF-1:0]} : pre;
  assign nxt = (op_sel == 2'b11) ? op_a : fin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid && (op_sel != 2'b11);
      if (in_valid) result <= nxt;
    end
  end

  // R9 / R8: valid follows only legal requests
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid) && $past(op_sel) != 2'b11));
  a_r8_illegal_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b11) |=> (!out_valid && result == $past(op_a)));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  a_r7_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(int_mode)) |-> (result[FLEN-1:HALF] == {HI{result[SB]}}));
  a_r6_boxed_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(int_mode)) |-> (&result[FLEN-1:HALF]));
  a_r1_magnitude: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (result[SB-1:0] ==
      (($past(int_mode) || &$past(op_a[FLEN-1:HALF])) ? $past(op_a[SB-1:0]) : CANON[SB-1:0])));
endmodule

// File: tb/hsgn_inject_test.sv
module hsgn_inject_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, in_valid = 0, same_reg = 0, int_mode = 0;
  logic [63:0] op_a = 0, op_b = 0;
  logic [1:0] op_sel = 0;
  logic out_valid;
  logic [63:0] result;
  int checks = 0, failures = 0;
  logic [63:0] held = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsgn_inject uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .same_reg(same_reg), .op_sel(op_sel), .int_mode(int_mode), .out_valid(out_valid), .result(result));

  function automatic logic [63:0] chk(input logic [63:0] v, input logic im);
    return (im || v[63:16] == 48'hFFFF_FFFF_FFFF) ? v : 64'hFFFF_FFFF_FFFF_7E00;
  endfunction

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic sr, input logic [1:0] s, input logic im);
    logic [63:0] x, y, r;
    if (s == 2'b11) return a;
    x = chk(a, im);
    y = sr ? x : chk(b, im);
    case (s)
      2'b00: r = sr ? x : {y[63:16], y[15], x[14:0]};
      2'b01: r = {x[63:16], ~y[15], x[14:0]};
      default: r = sr ? {x[63:16], 1'b0, x[14:0]} : {x[63:16], x[15] ^ y[15], x[14:0]};
    endcase
    if (im) r = {{48{r[15]}}, r[15:0]};
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic v, input logic [63:0] a, input logic [63:0] b,
                     input logic sr, input logic [1:0] s, input logic im);
    logic [63:0] e;
    in_valid = v; op_a = a; op_b = b; same_reg = sr; op_sel = s; int_mode = im;
    e = v ? model(a, b, sr, s, im) : held;
    @(posedge clk); #1;
    check(req, {63'd0, out_valid}, {63'd0, v && s != 2'b11});
    check(req, result, e);
    held = e;
    in_valid = 0;
  endtask

  function automatic logic [63:0] rnd_op();
    logic [63:0] v;
    v = {$urandom, $urandom};
    if ($urandom_range(1, 0) == 1) v[63:16] = '1;
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset valid", {63'd0, out_valid}, 64'd0);
    check("R9 reset result", result, 64'd0);
    rst_n = 1;
    // R2 copy sign from second operand
    run("R2", 1, 64'hFFFF_FFFF_FFFF_3C00, 64'hFFFF_FFFF_FFFF_8000, 0, 2'b00, 0);
    // R3 negated sign
    run("R3", 1, 64'hFFFF_FFFF_FFFF_BC00, 64'hFFFF_FFFF_FFFF_8000, 0, 2'b01, 0);
    // R4 xor sign
    run("R4", 1, 64'hFFFF_FFFF_FFFF_BC00, 64'hFFFF_FFFF_FFFF_8001, 0, 2'b10, 0);
    // R6 bad second operand replaced by canonical NaN
    run("R6", 1, 64'hFFFF_FFFF_FFFF_BC00, 64'h0000_0000_0000_8000, 0, 2'b00, 0);
    run("R6 bad a", 1, 64'h1234_FFFF_FFFF_3C00, 64'hFFFF_FFFF_FFFF_8000, 0, 2'b10, 0);
    // R5 same register, bad second operand must have no effect
    run("R5 move", 1, 64'hFFFF_FFFF_FFFF_C123, 64'h0, 1, 2'b00, 0);
    run("R5 neg", 1, 64'hFFFF_FFFF_FFFF_4123, 64'h0, 1, 2'b01, 0);
    run("R5 abs", 1, 64'hFFFF_FFFF_FFFF_C123, 64'hFFFF_FFFF_FFFF_0000, 1, 2'b10, 0);
    // R7 integer mode: no check, sign extension
    run("R7", 1, 64'h0000_0000_0000_3C00, 64'h0000_0000_0000_8000, 0, 2'b00, 1);
    run("R7 pos", 1, 64'h1111_2222_3333_BC00, 64'h0, 0, 2'b01, 1);
    // R8 illegal select passes raw first operand
    run("R8", 1, 64'h0123_4567_89AB_CDEF, 64'h0, 0, 2'b11, 0);
    // R9 hold when idle
    run("R9 idle", 0, 64'hFFFF_FFFF_FFFF_1111, 64'h0, 0, 2'b00, 0);
    // R1 random magnitude and mixed cases
    for (int i = 0; i < 400; i++) begin
      run("R1 random", $urandom_range(3, 0) != 0, rnd_op(), rnd_op(), $urandom_range(3, 0) == 0,
          2'($urandom_range(3, 0)), $urandom_range(3, 0) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule